// File: doc/BRIEF.md
# Conversion Sequencer with Result Flags

This block sits between the decimation filter of an oversampling converter and the register bus. Software writes a start bit and selects a run mode and a per-run count of filter outputs. The block decides which filter outputs become results, holds the latest result in a register, and tracks two status flags. One flag means "unread result present". The other means "a result was overwritten before it was read". Both flags are combined into one interrupt request, and each flag has its own enable.

There are two run modes. In single mode, one start runs a programmed number of filter outputs. Only the final output is kept. The start bit is then cleared by hardware. In continuous mode, every filter output is kept until software clears the start bit. Once the start bit is cleared, nothing still in flight is written.

Top module: `cvt_seq_top`

## Requirements
- R1: After reset the result is 0, the start bit, ready flag, overrun flag and interrupt request are all 0.
- R2: In single mode (mode input 0), a start with delay field value k (2 bits, 0..3) completes on the (k+1)-th filter output. On that same clock edge the result register takes that output, the ready flag sets and the start bit clears.
- R3: In single mode the filter outputs before the last one of the run leave the result register and ready flag unchanged.
- R4: While a single-mode run is active, start-bit writes of either value have no effect: the start bit stays 1 and the output count continues.
- R5: In continuous mode (mode input 1), every filter output arriving while the start bit is 1 is written to the result register, and the start bit stays 1.
- R6: Writing 0 to the start bit in continuous mode clears it on the next edge. A filter output arriving in that same cycle is not written.
- R7: Filter outputs arriving while the start bit is 0 leave the result register and flags unchanged.
- R8: The ready flag sets on every result write and clears on a result-read strobe. A write in the same cycle as a read leaves it set.
- R9: The overrun flag sets when a result is written while the ready flag is 1 and no read strobe is present in that cycle. A read does not clear it; only the overrun-clear strobe clears it.
- R10: The interrupt request is 1 exactly when (ready flag AND ready enable) OR (overrun flag AND overrun enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_wr | input | 1 | Software write strobe for the start bit |
| start_wdata | input | 1 | Value written to the start bit |
| mode_cont | input | 1 | 0 = single, 1 = continuous; latched at start |
| dly_sel | input | DLY_W | Single mode: outputs per run minus one; latched at start |
| flt_valid | input | 1 | Filter output strobe |
| flt_data | input | DW | Filter output value |
| rd_strobe | input | 1 | Result register read |
| ovf_clr | input | 1 | Software clear of the overrun flag |
| ie_rdy | input | 1 | Interrupt enable for the ready flag |
| ie_ovf | input | 1 | Interrupt enable for the overrun flag |
| start_q | output | 1 | Start bit readback |
| result | output | DW | Result register |
| rdy_flag | output | 1 | Result-ready flag |
| ovf_flag | output | 1 | Overrun flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with DW=12 and DLY_W=2. This keeps the data narrow, while the 2-bit delay field still reaches both its smallest (one output) and largest (four outputs) settings. Every filter value the bench sends is unique and nonzero, so each write to the result register shows up as a change that the scoreboard can match against its queue. The bench also covers a read and a write in the same cycle, and a stop in the same cycle as a filter output.

// File: rtl/cvt_seq_pkg.sv
package cvt_seq_pkg;

  // True when the output counted by cnt is the final one of a single run.
  function automatic logic run_is_last(input logic [7:0] cnt, input logic [7:0] dly);
    return cnt == dly;
  endfunction

  // Next overrun state: the set term has priority over the clear strobe.
  function automatic logic ovf_next(input logic cur, input logic wr, input logic rdy,
                                    input logic rd, input logic clr);
    if (wr && rdy && !rd) return 1'b1;
    if (clr)              return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/cvt_ctrl.sv
module cvt_ctrl
  import cvt_seq_pkg::*;
#(
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             start_wdata,
  input  logic             mode_cont,
  input  logic [DLY_W-1:0] dly_sel,
  input  logic             flt_valid,
  output logic             start_q,
  output logic             mode_q,
  output logic             wr_evt
);
  localparam int CNT_W = DLY_W;

  logic [CNT_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly_q;
  logic             single_busy;
  logic             wr_accept;
  logic             stop_req;
  logic             last_out;

  assign single_busy = start_q && !mode_q;
  assign wr_accept   = start_wr && !single_busy;
  assign stop_req    = wr_accept && !start_wdata;
  assign last_out    = run_is_last(8'(cnt_q), 8'(dly_q));

  always_comb begin
    wr_evt = 1'b0;
    if (start_q && flt_valid) begin
      if (mode_q) wr_evt = !stop_req;
      else        wr_evt = last_out;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      mode_q  <= 1'b0;
      dly_q   <= '0;
      cnt_q   <= '0;
    end else if (stop_req) begin
      start_q <= 1'b0;
    end else if (wr_accept && start_wdata && !start_q) begin
      start_q <= 1'b1;
      mode_q  <= mode_cont;
      dly_q   <= dly_sel;
      cnt_q   <= '0;
    end else if (single_busy && flt_valid) begin
      if (last_out) start_q <= 1'b0;
      else          cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (single_busy && !flt_valid) |=> start_q); // R4

  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !mode_q) |=> !start_q); // R2

  AST_STOP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> !wr_evt); // R6

endmodule

// File: rtl/cvt_result.sv
module cvt_result
  import cvt_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_strobe,
  input  logic          ovf_clr,
  output logic [DW-1:0] result,
  output logic          rdy_flag,
  output logic          ovf_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      rdy_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_evt) result <= wr_data;
      if (wr_evt)         rdy_flag <= 1'b1;
      else if (rd_strobe) rdy_flag <= 1'b0;
      ovf_flag <= ovf_next(ovf_flag, wr_evt, rdy_flag, rd_strobe, ovf_clr);
    end
  end

  AST_RDY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> rdy_flag); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R9

endmodule

// File: rtl/cvt_irq.sv
module cvt_irq (
  input  logic rdy_flag,
  input  logic ovf_flag,
  input  logic ie_rdy,
  input  logic ie_ovf,
  output logic irq
);
  logic [1:0] src;
  assign src = {ovf_flag & ie_ovf, rdy_flag & ie_rdy};
  assign irq = |src;

  always_comb begin
    if (!ie_rdy && !ie_ovf)
      AST_IRQ_MASKED: assert (!irq); // R10
  end
endmodule

// File: rtl/cvt_seq_top.sv
module cvt_seq_top #(
  parameter int DW    = 16,
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             start_wdata,
  input  logic             mode_cont,
  input  logic [DLY_W-1:0] dly_sel,
  input  logic             flt_valid,
  input  logic [DW-1:0]    flt_data,
  input  logic             rd_strobe,
  input  logic             ovf_clr,
  input  logic             ie_rdy,
  input  logic             ie_ovf,
  output logic             start_q,
  output logic [DW-1:0]    result,
  output logic             rdy_flag,
  output logic             ovf_flag,
  output logic             irq
);
  logic wr_evt;
  logic mode_q;

  cvt_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_wdata(start_wdata),
    .mode_cont(mode_cont), .dly_sel(dly_sel), .flt_valid(flt_valid),
    .start_q(start_q), .mode_q(mode_q), .wr_evt(wr_evt)
  );

  cvt_result #(.DW(DW)) u_res (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_data(flt_data),
    .rd_strobe(rd_strobe), .ovf_clr(ovf_clr), .result(result),
    .rdy_flag(rdy_flag), .ovf_flag(ovf_flag)
  );

  cvt_irq u_irq (
    .rdy_flag(rdy_flag), .ovf_flag(ovf_flag), .ie_rdy(ie_rdy), .ie_ovf(ie_ovf),
    .irq(irq)
  );

  AST_IDLE_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && flt_valid) |=> $stable(result)); // R7

  AST_CONT_KEEPS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && mode_q && !start_wr) |=> start_q); // R5

endmodule

// File: tb/sim_cvt_seq_top.sv
module sim_cvt_seq_top;
  localparam int DW = 12;
  localparam int DLY_W = 2;

  logic clk = 0, rst_n = 0;
  logic start_wr = 0, start_wdata = 0, mode_cont = 0;
  logic [DLY_W-1:0] dly_sel = '0;
  logic flt_valid = 0;
  logic [DW-1:0] flt_data = '0;
  logic rd_strobe = 0, ovf_clr = 0, ie_rdy = 0, ie_ovf = 0;
  logic start_q, rdy_flag, ovf_flag, irq;
  logic [DW-1:0] result;

  int checks = 0, failures = 0, cyc = 0;
  logic [DW-1:0] expq[$];
  logic [DW-1:0] last_res = '0;
  logic done = 0;

  always #2.5 clk = ~clk;

  cvt_seq_top #(.DW(DW), .DLY_W(DLY_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_wdata(start_wdata),
    .mode_cont(mode_cont), .dly_sel(dly_sel), .flt_valid(flt_valid),
    .flt_data(flt_data), .rd_strobe(rd_strobe), .ovf_clr(ovf_clr),
    .ie_rdy(ie_rdy), .ie_ovf(ie_ovf), .start_q(start_q), .result(result),
    .rdy_flag(rdy_flag), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One edge: inputs set at negedge take effect at posedge; check at next negedge.
  task automatic tick();
    @(posedge clk); @(negedge clk);
    start_wr = 0; flt_valid = 0; rd_strobe = 0; ovf_clr = 0;
  endtask

  task automatic do_start(input logic cont, input logic [DLY_W-1:0] d);
    start_wr = 1; start_wdata = 1; mode_cont = cont; dly_sel = d; tick();
  endtask

  // Driver: sends a filter output and pushes it when it should become a result.
  task automatic send(input logic [DW-1:0] v, input logic expect_wr);
    flt_valid = 1; flt_data = v;
    if (expect_wr) expq.push_back(v);
    tick();
  endtask

  // Monitor: every result change must match the next expected item.
  always @(posedge clk) begin
    #1;
    if (rst_n && result !== last_res) begin
      checks++;
      if (expq.size() == 0) begin
        failures++;
        $display("FAIL R3 unexpected write actual=%0h expected=none", result);
      end else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        if (e !== result) begin
          failures++;
          $display("FAIL R2 result actual=%0h expected=%0h", result, e);
        end
      end
      last_res = result;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=5000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 result", 32'(result), 0);
    chk("R1 start", 32'(start_q), 0);
    chk("R1 rdy", 32'(rdy_flag), 0);
    chk("R1 ovf", 32'(ovf_flag), 0);
    chk("R1 irq", 32'(irq), 0);
    rst_n = 1; tick();
    ie_rdy = 1; ie_ovf = 1;

    // R7: idle filter output ignored
    send(12'h0A1, 0);
    chk("R7 rdy idle", 32'(rdy_flag), 0);
    chk("R7 result idle", 32'(result), 0);

    // R2: single, delay 0 -> one output
    do_start(0, 2'd0);
    chk("R2 start set", 32'(start_q), 1);
    send(12'h101, 1);
    chk("R2 start cleared", 32'(start_q), 0);
    chk("R8 rdy set", 32'(rdy_flag), 1);
    chk("R10 irq rdy", 32'(irq), 1);
    rd_strobe = 1; tick();
    chk("R8 rdy cleared by read", 32'(rdy_flag), 0);
    chk("R10 irq low", 32'(irq), 0);

    // R2/R3/R4: single, delay 3 -> four outputs
    do_start(0, 2'd3);
    send(12'h202, 0); send(12'h203, 0); send(12'h204, 0);
    chk("R3 no rdy mid-run", 32'(rdy_flag), 0);
    chk("R3 result kept", 32'(result), 12'h101);
    start_wr = 1; start_wdata = 0; tick();
    chk("R4 clear ignored", 32'(start_q), 1);
    start_wr = 1; start_wdata = 1; dly_sel = 2'd0; tick();
    chk("R4 restart ignored", 32'(start_q), 1);
    send(12'h205, 1);
    chk("R2 done after 4", 32'(start_q), 0);
    chk("R2 result last", 32'(result), 12'h205);
    chk("R9 no ovf yet", 32'(ovf_flag), 0);

    // R9: overrun on unread result
    do_start(0, 2'd0);
    send(12'h306, 1);
    chk("R9 ovf set", 32'(ovf_flag), 1);
    rd_strobe = 1; tick();
    chk("R9 read keeps ovf", 32'(ovf_flag), 1);
    chk("R10 irq ovf", 32'(irq), 1);
    ie_ovf = 0; #1;
    chk("R10 ovf masked", 32'(irq), 0);
    ovf_clr = 1; tick();
    chk("R9 ovf cleared", 32'(ovf_flag), 0);
    ie_ovf = 1;

    // R5/R8/R9: continuous
    do_start(1, 2'd2);
    send(12'h407, 1);
    chk("R5 rdy", 32'(rdy_flag), 1);
    chk("R5 start stays", 32'(start_q), 1);
    rd_strobe = 1; send(12'h408, 1);
    chk("R8 write wins over read", 32'(rdy_flag), 1);
    chk("R9 read same cycle no ovf", 32'(ovf_flag), 0);
    send(12'h409, 1);
    chk("R9 ovf continuous", 32'(ovf_flag), 1);
    chk("R5 result", 32'(result), 12'h409);
    rd_strobe = 1; ovf_clr = 1; tick();

    // R6: stop with a filter output in the same cycle
    start_wr = 1; start_wdata = 0; send(12'h50A, 0);
    chk("R6 start cleared", 32'(start_q), 0);
    chk("R6 result unchanged", 32'(result), 12'h409);
    send(12'h50B, 0);
    chk("R7 after stop result", 32'(result), 12'h409);
    chk("R7 after stop rdy", 32'(rdy_flag), 0);
    tick(); tick();
    chk("R3 scoreboard empty", 32'(expq.size()), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule